// File: doc/BRIEF.md
# Cross-chip source egress mask table

This block sits in the forwarding path of a switch chip that is cascaded with other switch chips. Frames forwarded in from another chip carry the identity of their original source: a device number, and either a port number or a trunk number with a flag saying which one it is. The block turns that identity into a table index. It reads the entry at that index and returns a per-port egress-permit mask. Bit i of the mask lets the frame leave local port i when it is 1 and blocks it when it is 0.

Software reaches the table through two registers. The command register carries a start/busy flag, an operation code and an entry address. The data register carries a mask. Three commands are defined: fill the whole table with ones, store the data register into one entry, and load one entry into the data register. The fill walks the table one entry per clock. A frame lookup always takes precedence over a single-entry register access that wants the table in the same cycle.

The index is formed in one of two bit-split modes. In the first, five device bits sit above four port bits. In the second, four device bits sit above five port bits. When the source is a trunk, the local device number stands in for the source device and the trunk number stands in for the port.

Top module: `xcpm_table`

## Requirements
- R1: After reset the command register reads 0x0000 (not busy), the data register reads 0x0000 and `lk_mask_valid` is 0.
- R2: Writing the command register with bit 15 set and operation code 1 in bits 14:12 sets every one of the 512 entries to all ones. Bit 15 then reads 1 for exactly 512 cycles.
- R3: A lookup issued while the fill is running returns an all-ones mask.
- R4: Writing the data register (`reg_sel`=1) and then the command register with bit 15 set, code 3 and the entry address in bits 8:0 stores the mask in that entry. Without a colliding lookup, bit 15 reads 1 for exactly one cycle.
- R5: Code 4 with an address loads that entry into the data register, which is readable once bit 15 reads 0. The data register keeps only the low 11 bits of a write, and bits 15:11 read as 0.
- R6: Any operation code other than 1, 3 or 4 completes after one busy cycle and changes no entry.
- R7: While bit 15 reads 1, writes to the command register and to the data register are ignored.
- R8: A command-register write with bit 15 clear starts nothing and leaves the command register unchanged.
- R9: With `mode_wide`=0 and `lk_is_trunk`=0, the index is {src_dev[4:0], src_port[3:0]}.
- R10: With `mode_wide`=0 and `lk_is_trunk`=1, the index is {local_dev[4:0], src_port[3:0]}, where src_port carries the trunk number.
- R11: With `mode_wide`=1, the index is {dev[3:0], src_port[4:0]}, where dev is `lk_src_dev` for a port source and `local_dev` for a trunk source.
- R12: A lookup presented with `lk_valid` in one cycle shows its mask on `lk_mask`, with `lk_mask_valid` high, in the next cycle only.
- R13: When a lookup and a pending write or read want the table in the same cycle, the lookup is served from the current content and the register access completes one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Content of the selected register |
| mode_wide | input | 1 | Index split: 0 five device and four port bits, 1 four and five |
| local_dev | input | 5 | This chip's device number |
| lk_valid | input | 1 | Lookup request |
| lk_is_trunk | input | 1 | Source is a trunk |
| lk_src_dev | input | 5 | Source device of the frame |
| lk_src_port | input | 5 | Source port or trunk number |
| lk_mask | output | 11 | Egress-permit mask, bit i for local port i |
| lk_mask_valid | output | 1 | `lk_mask` holds a lookup result |

## Verification
The index former is tried with source identities in all four combinations of split mode and trunk flag. These include fields whose unused top bit is set, so a design that keeps a dropped bit would pick a different entry. Each vector first writes a distinct mask to the entry it expects. A wrong index therefore returns either the all-ones fill value or another vector's mask, never the expected one. The fill is watched both by counting its busy cycles and by probing it with a lookup mid-sweep. A second fill is disturbed by register writes, which separates a design that ignores commands while busy from one that aborts the sweep. A lookup placed on the very cycle a write wants the table shows whether the old content is returned and the write is delayed, rather than lost.

// File: rtl/xcpm_pkg.sv
package xcpm_pkg;

    localparam int REG_W     = 16;
    localparam int START_BIT = 15;
    localparam int OP_LSB    = 12;
    localparam int OPC_W     = 3;

    localparam logic [OPC_W-1:0] OPC_INIT  = 3'd1;
    localparam logic [OPC_W-1:0] OPC_WRITE = 3'd3;
    localparam logic [OPC_W-1:0] OPC_READ  = 3'd4;

    localparam logic SEL_CMD  = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_STEP  = 2'd1,
        ENG_SWEEP = 2'd2
    } eng_state_e;

endpackage

// File: rtl/xcpm_index.sv
module xcpm_index #(
    parameter int IDX_W = 9
) (
    input  logic             mode_wide,
    input  logic             is_trunk,
    input  logic [IDX_W-5:0] src_dev,
    input  logic [IDX_W-5:0] src_port,
    input  logic [IDX_W-5:0] local_dev,
    output logic [IDX_W-1:0] idx
);
    // wide field = IDX_W-4 bits, narrow field = IDX_W-5 bits
    localparam int FW = IDX_W - 4;
    localparam int NW = IDX_W - 5;

    logic [FW-1:0] dev_pick;

    always_comb begin
        dev_pick = is_trunk ? local_dev : src_dev;
        if (mode_wide) begin
            idx = {dev_pick[NW-1:0], src_port[FW-1:0]};
        end else begin
            idx = {dev_pick[FW-1:0], src_port[NW-1:0]};
        end
    end

endmodule

// File: rtl/xcpm_store.sv
module xcpm_store #(
    parameter int IDX_W  = 9,
    parameter int MASK_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [MASK_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [MASK_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [MASK_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/xcpm_engine.sv
module xcpm_engine
    import xcpm_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int MASK_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              lk_claim,
    input  logic [MASK_W-1:0] tbl_rdata,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_waddr,
    output logic [MASK_W-1:0] tbl_wdata,
    output logic [IDX_W-1:0]  tbl_raddr,
    output logic              busy,
    output logic              sweeping,
    output logic              step_pending,
    output logic [OPC_W-1:0]  cmd_op,
    output logic [IDX_W-1:0]  cmd_addr,
    output logic [MASK_W-1:0] data_reg
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    typedef struct packed {
        eng_state_e        st;
        logic [OPC_W-1:0]  op;
        logic [IDX_W-1:0]  addr;
        logic [MASK_W-1:0] data;
        logic [IDX_W-1:0]  sweep;
    } eng_t;

    eng_t q, d;
    logic touches_table;
    logic [OPC_W-1:0] new_op;

    always_comb begin
        d             = q;
        tbl_we        = 1'b0;
        tbl_waddr     = q.addr;
        tbl_wdata     = q.data;
        touches_table = (q.op == OPC_WRITE) || (q.op == OPC_READ);
        new_op        = reg_wdata[OP_LSB +: OPC_W];
        case (q.st)
            ENG_IDLE: begin
                if (reg_wr) begin
                    if (reg_sel == SEL_DATA) begin
                        d.data = reg_wdata[MASK_W-1:0];
                    end else if (reg_wdata[START_BIT]) begin
                        d.op    = new_op;
                        d.addr  = reg_wdata[IDX_W-1:0];
                        d.sweep = '0;
                        d.st    = (new_op == OPC_INIT) ? ENG_SWEEP : ENG_STEP;
                    end
                end
            end
            ENG_STEP: begin
                // a lookup owns the table this cycle: hold the access
                if (!(touches_table && lk_claim)) begin
                    if (q.op == OPC_WRITE) begin
                        tbl_we = 1'b1;
                    end
                    if (q.op == OPC_READ) begin
                        d.data = tbl_rdata;
                    end
                    d.st = ENG_IDLE;
                end
            end
            ENG_SWEEP: begin
                tbl_we    = 1'b1;
                tbl_waddr = q.sweep;
                tbl_wdata = '1;
                d.sweep   = q.sweep + 1'b1;
                if (q.sweep == LAST_IDX) begin
                    d.st = ENG_IDLE;
                end
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tbl_raddr    = q.addr;
    assign busy         = (q.st != ENG_IDLE);
    assign sweeping     = (q.st == ENG_SWEEP);
    assign step_pending = (q.st == ENG_STEP) && touches_table;
    assign cmd_op       = q.op;
    assign cmd_addr     = q.addr;
    assign data_reg     = q.data;

endmodule

// File: rtl/xcpm_table.sv
module xcpm_table
    import xcpm_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int MASK_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              mode_wide,
    input  logic [IDX_W-5:0]  local_dev,
    input  logic              lk_valid,
    input  logic              lk_is_trunk,
    input  logic [IDX_W-5:0]  lk_src_dev,
    input  logic [IDX_W-5:0]  lk_src_port,
    output logic [MASK_W-1:0] lk_mask,
    output logic              lk_mask_valid
);
    typedef struct packed {
        logic              vld;
        logic [MASK_W-1:0] mask;
    } lk_t;

    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  eng_raddr;
    logic [IDX_W-1:0]  rd_addr;
    logic [MASK_W-1:0] rd_data;
    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_waddr;
    logic [MASK_W-1:0] tbl_wdata;
    logic              eng_busy;
    logic              eng_sweeping;
    logic              eng_step_pending;
    logic [OPC_W-1:0]  eng_op;
    logic [IDX_W-1:0]  eng_addr;
    logic [MASK_W-1:0] eng_data;
    lk_t               lk_q, lk_d;

    xcpm_index #(.IDX_W(IDX_W)) u_index (
        .mode_wide (mode_wide),
        .is_trunk  (lk_is_trunk),
        .src_dev   (lk_src_dev),
        .src_port  (lk_src_port),
        .local_dev (local_dev),
        .idx       (lk_idx)
    );

    xcpm_engine #(.IDX_W(IDX_W), .MASK_W(MASK_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .lk_claim     (lk_valid),
        .tbl_rdata    (rd_data),
        .tbl_we       (tbl_we),
        .tbl_waddr    (tbl_waddr),
        .tbl_wdata    (tbl_wdata),
        .tbl_raddr    (eng_raddr),
        .busy         (eng_busy),
        .sweeping     (eng_sweeping),
        .step_pending (eng_step_pending),
        .cmd_op       (eng_op),
        .cmd_addr     (eng_addr),
        .data_reg     (eng_data)
    );

    // single read port: the lookup wins it
    assign rd_addr = lk_valid ? lk_idx : eng_raddr;

    xcpm_store #(.IDX_W(IDX_W), .MASK_W(MASK_W)) u_store (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        lk_d     = lk_q;
        lk_d.vld = lk_valid;
        if (lk_valid) begin
            lk_d.mask = eng_sweeping ? '1 : rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign lk_mask       = lk_q.mask;
    assign lk_mask_valid = lk_q.vld;

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_DATA) begin
            reg_rdata[MASK_W-1:0] = eng_data;
        end else begin
            reg_rdata[START_BIT]          = eng_busy;
            reg_rdata[OP_LSB +: OPC_W]    = eng_op;
            reg_rdata[IDX_W-1:0]          = eng_addr;
        end
    end

endmodule

// File: rtl/xcpm_table_chk.sv
module xcpm_table_chk #(
    parameter int IDX_W  = 9,
    parameter int MASK_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [MASK_W-1:0] lk_mask,
    input logic              lk_mask_valid,
    input logic              busy,
    input logic              sweeping,
    input logic              step_pending,
    input logic              tbl_we,
    input logic [2:0]        cmd_op,
    input logic [IDX_W-1:0]  cmd_addr
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W:0] sweep_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_cnt <= '0;
        end else if (sweeping) begin
            sweep_cnt <= sweep_cnt + 1'b1;
        end else begin
            sweep_cnt <= '0;
        end
    end

    p_sweep_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && sweep_cnt == (IDX_W+1)'(DEPTH-1)) |=> !sweeping);

    p_sweep_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |-> (sweep_cnt < (IDX_W+1)'(DEPTH)));

    p_sweep_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && sweeping) |=> (lk_mask == '1));

    p_step_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pending && !lk_valid) |=> !busy);

    p_other_code_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sweeping && !step_pending) |=> !busy);

    p_cmd_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_op) && $stable(cmd_addr)));

    p_result_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_mask_valid);

    p_no_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_mask_valid);

    p_stall_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pending && lk_valid) |=> step_pending);

    p_no_write_under_lookup_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && !sweeping) |-> !lk_valid);

endmodule

bind xcpm_table xcpm_table_chk #(.IDX_W(IDX_W), .MASK_W(MASK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_mask       (lk_mask),
    .lk_mask_valid (lk_mask_valid),
    .busy          (eng_busy),
    .sweeping      (eng_sweeping),
    .step_pending  (eng_step_pending),
    .tbl_we        (tbl_we),
    .cmd_op        (eng_op),
    .cmd_addr      (eng_addr)
);

// File: tb/sim_xcpm_table.sv
`timescale 1ns/1ps
module sim_xcpm_table;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mode_wide = 1'b0;
    logic [4:0]  local_dev = '0;
    logic        lk_valid = 1'b0;
    logic        lk_is_trunk = 1'b0;
    logic [4:0]  lk_src_dev = '0;
    logic [4:0]  lk_src_port = '0;
    logic [10:0] lk_mask;
    logic        lk_mask_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(HALF) clk = ~clk;

    xcpm_table u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_wide(mode_wide),
        .local_dev(local_dev), .lk_valid(lk_valid), .lk_is_trunk(lk_is_trunk),
        .lk_src_dev(lk_src_dev), .lk_src_port(lk_src_port),
        .lk_mask(lk_mask), .lk_mask_valid(lk_mask_valid)
    );

    // {mode, trunk, dev[5], port[5], local[5], expected index[9]}
    localparam int NV = 8;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 1'b0, 5'h13, 5'h0A, 5'h02, 9'h13A},
        {1'b0, 1'b0, 5'h1F, 5'h1F, 5'h00, 9'h1FF},
        {1'b0, 1'b1, 5'h07, 5'h15, 5'h0C, 9'h0C5},
        {1'b1, 1'b0, 5'h1B, 5'h16, 5'h05, 9'h176},
        {1'b1, 1'b1, 5'h03, 5'h09, 5'h1A, 9'h149},
        {1'b0, 1'b1, 5'h1F, 5'h10, 5'h00, 9'h000},
        {1'b1, 1'b0, 5'h00, 5'h01, 5'h1F, 9'h001},
        {1'b0, 1'b0, 5'h00, 5'h11, 5'h07, 9'h001}
    };

    function automatic logic [10:0] mask_of(int i);
        return 11'((i * 97) ^ 'h155);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic sel, logic [15:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        reg_sel = 1'b0;
        #1;
        cyc = 0;
        while (reg_rdata[15] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic read_reg(logic sel, output logic [15:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic tbl_write(logic [8:0] a, logic [10:0] m, output int cyc);
        reg_write(1'b1, {5'b0, m});
        reg_write(1'b0, 16'hB000 | {7'b0, a});
        wait_idle(cyc);
    endtask

    task automatic tbl_read(logic [8:0] a, output logic [15:0] val);
        int cyc;
        reg_write(1'b0, 16'hC000 | {7'b0, a});
        wait_idle(cyc);
        read_reg(1'b1, val);
    endtask

    task automatic lookup(logic md, logic tr, logic [4:0] dv, logic [4:0] pt,
                          logic [4:0] lc, output logic [10:0] m, output logic v);
        @(negedge clk);
        mode_wide = md; lk_is_trunk = tr; lk_src_dev = dv; lk_src_port = pt;
        local_dev = lc; lk_valid = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0;
        m = lk_mask; v = lk_mask_valid;
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v16;
        logic [10:0] m;
        logic        mv;
        int          cyc;
        int          bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_reg(1'b0, v16); check("R1 cmd", v16, 16'h0000);
        read_reg(1'b1, v16); check("R1 data", v16, 16'h0000);
        check("R1 valid", {15'b0, lk_mask_valid}, 16'h0000);

        // R2 fill, counted; R3 lookup in the middle of it
        reg_write(1'b0, 16'h9000);
        reg_sel = 1'b0;
        #1;
        cyc = 0;
        while (reg_rdata[15] && cyc < 5000) begin
            if (cyc == 100) begin
                mode_wide = 1'b0; lk_is_trunk = 1'b0;
                lk_src_dev = 5'h1F; lk_src_port = 5'h0F; lk_valid = 1'b1;
            end
            if (cyc == 101) begin
                lk_valid = 1'b0;
                check("R3 sweep lookup", {5'b0, lk_mask}, 16'h07FF);
            end
            cyc++;
            @(negedge clk);
            #1;
        end
        check("R2 busy cycles", 16'(cyc), 16'd512);

        bad = 0;
        for (int a = 0; a < 512; a++) begin
            tbl_read(9'(a), v16);
            if (v16 !== 16'h07FF) bad++;
        end
        check("R2 all entries ones", 16'(bad), 16'd0);

        // R9 R10 R11 index vectors, R4 write, R5 read, R12 timing
        for (int i = 0; i < NV; i++) begin
            logic [25:0] vv;
            string tag;
            vv = VEC[i];
            tag = vv[25] ? "R11" : (vv[24] ? "R10" : "R9");
            tbl_write(vv[8:0], mask_of(i), cyc);
            if (i == 0) check("R4 busy one cycle", 16'(cyc), 16'd1);
            lookup(vv[25], vv[24], vv[23:19], vv[18:14], vv[13:9], m, mv);
            check(tag, {5'b0, m}, {5'b0, mask_of(i)});
            check("R12 valid", {15'b0, mv}, 16'h0001);
            tbl_read(vv[8:0], v16);
            check("R5 read back", v16, {5'b0, mask_of(i)});
        end
        @(negedge clk);
        check("R12 valid drops", {15'b0, lk_mask_valid}, 16'h0000);

        // R13 lookup collides with a pending write to entry 0x13A
        reg_write(1'b1, 16'h00F0);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'hB13A;
        @(negedge clk);
        reg_wr = 1'b0;
        mode_wide = 1'b0; lk_is_trunk = 1'b0; lk_src_dev = 5'h13; lk_src_port = 5'h0A;
        lk_valid = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0;
        #1;
        check("R13 lookup sees old", {5'b0, lk_mask}, {5'b0, mask_of(0)});
        check("R13 write held", {15'b0, reg_rdata[15]}, 16'h0001);
        @(negedge clk);
        #1;
        check("R13 write done", {15'b0, reg_rdata[15]}, 16'h0000);
        lookup(1'b0, 1'b0, 5'h13, 5'h0A, 5'h00, m, mv);
        check("R13 new value", {5'b0, m}, 16'h00F0);

        // R6 other codes
        reg_write(1'b0, 16'hA0C5);
        wait_idle(cyc);
        check("R6 code 2 busy", 16'(cyc), 16'd1);
        reg_write(1'b0, 16'hF0C5);
        wait_idle(cyc);
        check("R6 code 7 busy", 16'(cyc), 16'd1);
        tbl_read(9'h0C5, v16);
        check("R6 entry unchanged", v16, {5'b0, mask_of(2)});

        // R8 bit 15 clear: reads back last command (read of 0x0C5)
        reg_write(1'b0, 16'h3176);
        read_reg(1'b0, v16);
        check("R8 no start", v16, 16'h40C5);
        tbl_read(9'h176, v16);
        check("R8 entry unchanged", v16, {5'b0, mask_of(3)});

        // R5 data register width
        reg_write(1'b1, 16'hFFFF);
        read_reg(1'b1, v16);
        check("R5 data truncation", v16, 16'h07FF);
        reg_write(1'b1, 16'h0321);

        // R7 writes while busy during a second fill
        reg_write(1'b0, 16'h9000);
        reg_write(1'b1, 16'h0123);
        reg_write(1'b0, 16'hB1FF);
        read_reg(1'b0, v16);
        check("R7 cmd while busy", v16, 16'h9000);
        wait_idle(cyc);
        read_reg(1'b1, v16);
        check("R7 data kept", v16, 16'h0321);
        tbl_read(9'h1FF, v16);
        check("R7 fill completed", v16, 16'h07FF);
        tbl_read(9'h000, v16);
        check("R7 fill entry 0", v16, 16'h07FF);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule